// File: doc/BRIEF.md
# Tap-Addressed Shift-Register FIFO

A small single-clock first-in first-out buffer whose storage is a delay line rather than a RAM with separate read and write pointers. Each accepted write shifts every stored word one stage deeper and loads the new word into stage 0. An up/down occupancy counter keeps track of how many words are held. The counter value minus one selects the delay-line stage that drives the read data port, so the oldest word is always presented there.

A read only lowers the counter and leaves the stored data where it is. When a read and a write are accepted in the same cycle, the line shifts and the counter holds its value. The data width and depth are parameters. The defaults are 16 bits wide and 16 entries deep.

Top module: `tap_fifo`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, count_o is 0, empty_o is 1 and full_o is 0. Reset does not clear the stored words.
- R2: A write alone (push_i=1, pop_i=0) when count_o < DEPTH increments count_o by one at the next rising edge.
- R3: A read alone (pop_i=1, push_i=0) when count_o > 0 decrements count_o by one at the next rising edge. The stored words do not move, and the next older word appears on rd_data_o.
- R4: push_i and pop_i together, when 0 < count_o < DEPTH, leave count_o unchanged and accept both the write and the read.
- R5: Whenever count_o > 0, rd_data_o equals the oldest accepted word that has not yet been read. It is read combinationally from stage count_o-1, where stage 0 holds the newest word.
- R6: empty_o is 1 exactly when count_o is 0, and full_o is 1 exactly when count_o equals DEPTH (16 by default, count_o is 5 bits wide).
- R7: A write alone while full_o is 1 is ignored: count_o and all stored words are unchanged.
- R8: A read while empty_o is 1 is ignored. push_i and pop_i together while empty act as a write alone.
- R9: push_i and pop_i together while full_o is 1 accept both. The oldest word leaves the line and count_o stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the occupancy counter |
| push_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to write |
| pop_i | input | 1 | Read request, consumes the word shown on rd_data_o |
| rd_data_o | output | DATA_W | Oldest stored word, valid while empty_o is 0 |
| count_o | output | $clog2(DEPTH+1) | Number of stored words |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |

## Verification
The hardest situations to reach are at the two ends of the counter with both requests active. A simultaneous write and read while full must push the oldest word out of the last stage. A simultaneous write and read while empty must degrade to a write. The stimulus fills the buffer to exactly DEPTH words, tries an ignored write, and runs several combined cycles at full. It then drains the buffer completely and issues combined and lone reads at empty. A randomized mix of requests follows, and a queue model compares every word that is read.

// File: rtl/tap_fifo_pkg.sv
package tap_fifo_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/tap_fifo_line.sv
module tap_fifo_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [AW-1:0]     addr_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] stage_q [DEPTH];

  // storage is not reset
  always_ff @(posedge clk_i) begin
    if (shift_i) stage_q[0] <= din_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (shift_i) stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout_o = stage_q[addr_i];

  assert_head_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> stage_q[0] == $past(din_i));
  assert_line_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(stage_q[0]) && $stable(stage_q[DEPTH-1]));
endmodule

// File: rtl/tap_fifo_ctrl.sv
module tap_fifo_ctrl
  import tap_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             shift_o,
  output logic [AW-1:0]    addr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;
  cnt_op_e          op;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  // at full a write is taken only when a read frees the last stage
  assign push_ok = push_i && (!full_o || pop_ok);

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   op = CNT_INC;
      2'b01:   op = CNT_DEC;
      default: op = CNT_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (op)
        CNT_INC: cnt_q <= cnt_q + CNT_W'(1);
        CNT_DEC: cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign shift_o = push_ok;
  assign addr_o  = empty_o ? '0 : AW'(cnt_q - CNT_W'(1));
  assign count_o = cnt_q;

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  assert_push_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !full_o |=> count_o == $past(count_o) + CNT_W'(1));
  assert_pop_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !empty_o |=> count_o == $past(count_o) - CNT_W'(1));
  assert_both_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty_o |=> $stable(count_o));
  assert_full_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && full_o |=> $stable(count_o) && !$past(shift_o));
  assert_empty_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && empty_o |=> count_o == '0);
  assert_empty_both_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && push_i && empty_o |=> count_o == CNT_W'(1));
endmodule

// File: rtl/tap_fifo.sv
module tap_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic          shift;
  logic [AW-1:0] addr;

  tap_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .shift_o (shift),
    .addr_o  (addr),
    .count_o (count_o),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  tap_fifo_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .din_i   (wr_data_i),
    .addr_i  (addr),
    .dout_o  (rd_data_o)
  );

  assert_full_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && full_o |=> full_o);
endmodule

// File: tb/sim_tap_fifo.sv
module sim_tap_fifo;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 0;
  logic              rst_ni = 0;
  logic              push = 0, pop = 0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [CNT_W-1:0]  count;
  logic              empty, full;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] sb[$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tap_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push), .wr_data_i(wdata),
    .pop_i(pop), .rd_data_o(rdata), .count_o(count),
    .empty_o(empty), .full_o(full)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare flags and count against the scoreboard size
  task automatic chk_state(input string req);
    chk(count == CNT_W'(sb.size()), req, count, sb.size());
    chk(empty == (sb.size() == 0), {req, "/R6 empty"}, empty, sb.size() == 0);
    chk(full == (sb.size() == DEPTH), {req, "/R6 full"}, full, sb.size() == DEPTH);
  endtask

  // drive one cycle at the falling edge; model updates after the rising edge
  task automatic op(input bit p, input bit o, input logic [DATA_W-1:0] d, input string req);
    bit pa, oa;
    @(negedge clk);
    chk_state(req);
    oa = o && sb.size() > 0;
    pa = p && (sb.size() < DEPTH || oa);
    if (oa) chk(rdata == sb[0], {req, "/R5 data"}, rdata, sb[0]);
    push = p; pop = o; wdata = d;
    @(posedge clk);
    if (oa) void'(sb.pop_front());
    if (pa) sb.push_back(d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(count == 0 && empty && !full, "R1 in reset", {count, empty, full}, 2);
    rst_ni = 1;
    @(negedge clk);
    chk(count == 0 && empty && !full, "R1 after reset", {count, empty, full}, 2);

    for (int i = 0; i < 5; i++) op(1, 0, DATA_W'(16'h1000 + i), "R2");
    for (int i = 0; i < 2; i++) op(0, 1, '0, "R3");
    for (int i = 0; i < 4; i++) op(1, 1, DATA_W'(16'h2000 + i), "R4");
    while (sb.size() < DEPTH) op(1, 0, DATA_W'(16'h3000 + sb.size()), "R2 fill");
    op(0, 0, '0, "R6 full");
    for (int i = 0; i < 3; i++) op(1, 0, 16'hDEAD, "R7");
    for (int i = 0; i < 3; i++) op(1, 1, DATA_W'(16'h4000 + i), "R9");
    while (sb.size() > 0) op(0, 1, '0, "R3 drain");
    op(0, 1, '0, "R8 pop empty");
    op(0, 1, '0, "R8 pop empty");
    op(1, 1, 16'h5A5A, "R8 both empty");
    op(0, 1, '0, "R8 read back");
    // reset leaves storage: counter only
    for (int i = 0; i < 3; i++) op(1, 0, DATA_W'(16'h6000 + i), "R2");
    @(negedge clk); push = 0; pop = 0;
    rst_ni = 0; sb.delete();
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk(count == 0 && empty, "R1 re-reset", count, 0);
    for (int i = 0; i < 3000; i++) begin
      bit p = ($urandom_range(0, 99) < 55);
      bit o = ($urandom_range(0, 99) < 50);
      op(p, o, DATA_W'($urandom), "R5 mix");
    end
    while (sb.size() > 0) op(0, 1, '0, "R5 final drain");
    @(negedge clk); push = 0; pop = 0;
    chk_state("R6 end");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule